// File: doc/BRIEF.md
# Signal-quality acquisition and lock monitor

This block decides when a spread-spectrum receiver has acquired a signal and when it has lost it. The decision rests on a 15-bit bit-sync amplitude figure produced elsewhere. While acquiring, the block follows the strongest amplitude reported during each antenna dwell. When the dwell closes, it holds that value for readback and tests it against an acquisition threshold. Lock is declared only if a second, externally computed quality flag also passes in the same cycle.

Once locked, the block counts symbol strobes. On every 128th strobe it compares the most recent amplitude against a separate tracking threshold. If the amplitude is too weak, it drops back to acquisition and raises a one-cycle loss pulse. Thresholds and the readback value are each split into a 7-bit upper part (bits 14:8) and an 8-bit lower part (bits 7:0), to match a byte-wide register file.

Top module: `sq_lock_monitor`

## Requirements
- R1: After reset, `state` is 0 (idle), `best_hi`/`best_lo` read 0 and `lost` is 0.
- R2: In idle, `arm` high moves `state` to 1 (acquire) after the next edge. Amplitude reports and dwell ends that arrive in idle leave the readback at its old value.
- R3: In acquire, a dwell end latches into `{best_hi,best_lo}` the largest amplitude reported since the previous dwell end, including one reported in the dwell-end cycle itself. The tracking starts again from 0 for the next dwell, so a weaker dwell reads back a smaller value.
- R4: At a dwell end in acquire, `state` becomes 2 (locked) when the dwell's best value is greater than or equal to `{acq_thr_hi,acq_thr_lo}` and `sq2_pass` is high.
- R5: A dwell whose best value is below the acquisition threshold does not lock. A dwell that passes the amplitude test while `sq2_pass` is low does not lock either.
- R6: In locked, the amplitude is tested on the 128th `sym_strobe` after lock and on every 128th one after that. If it is strictly below `{trk_thr_hi,trk_thr_lo}`, `state` returns to 1 and `lost` is high for exactly one cycle. A value equal to the threshold keeps lock, and strobes before the 128th never drop lock.
- R7: The tracking test uses the most recent valid amplitude, including one in the testing cycle. If none has arrived since lock, it uses the value that acquired lock.
- R8: While locked, dwell ends and amplitude reports leave the readback unchanged.
- R9: Each 15-bit threshold is formed as upper part shifted left by 8, OR lower part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start acquisition from idle |
| acq_thr_hi | input | 7 | Acquisition threshold bits 14:8 |
| acq_thr_lo | input | 8 | Acquisition threshold bits 7:0 |
| trk_thr_hi | input | 7 | Tracking (drop) threshold bits 14:8 |
| trk_thr_lo | input | 8 | Tracking (drop) threshold bits 7:0 |
| meas_valid | input | 1 | Amplitude report strobe |
| meas | input | 15 | Bit-sync amplitude for the current antenna |
| dwell_end | input | 1 | Last cycle of an antenna dwell |
| sq2_pass | input | 1 | Second quality test passed |
| sym_strobe | input | 1 | One pulse per received symbol |
| state | output | 2 | 0 idle, 1 acquire, 2 locked |
| best_hi | output | 7 | Readback of dwell best, bits 14:8 |
| best_lo | output | 8 | Readback of dwell best, bits 7:0 |
| lost | output | 1 | One-cycle pulse when lock is dropped |

## Verification
The bench aims at the equality boundaries. An acquisition amplitude exactly at threshold must lock, and a tracking amplitude exactly at threshold must hold. A design using the wrong comparison would miss lock or drop it spuriously. The bench reports the peak in the same cycle as the dwell end, and also follows a strong dwell with a weak one. This exposes a design that ignores the final report or never clears its per-dwell maximum. Gapped symbol strobes and a test with no fresh amplitude since lock catch an off-by-one in the 128-symbol window and a stale or zeroed tracking sample. Amplitude passes paired with a failing second flag, and dwell ends while locked, confirm that neither can lock falsely or disturb the readback.

// File: rtl/sq_lock_monitor.sv
module sq_lock_monitor #(
  parameter int MEAS_W = 15,
  parameter int SYM_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [MEAS_W-9:0] acq_thr_hi,
  input  logic [7:0]        acq_thr_lo,
  input  logic [MEAS_W-9:0] trk_thr_hi,
  input  logic [7:0]        trk_thr_lo,
  input  logic              meas_valid,
  input  logic [MEAS_W-1:0] meas,
  input  logic              dwell_end,
  input  logic              sq2_pass,
  input  logic              sym_strobe,
  output logic [1:0]        state,
  output logic [MEAS_W-9:0] best_hi,
  output logic [7:0]        best_lo,
  output logic              lost
);

  localparam logic [SYM_W-1:0] SYM_LAST = {SYM_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ACQ = 2'd1, S_LOCK = 2'd2} st_t;

  st_t               st;
  logic [MEAS_W-1:0] dwell_best, held, last_meas;
  logic [SYM_W-1:0]  sym_cnt;

  wire [MEAS_W-1:0] acq_thr = {acq_thr_hi, acq_thr_lo};
  wire [MEAS_W-1:0] trk_thr = {trk_thr_hi, trk_thr_lo};
  wire [MEAS_W-1:0] cand    = (meas_valid && meas > dwell_best) ? meas : dwell_best;
  wire [MEAS_W-1:0] sample  = meas_valid ? meas : last_meas;
  wire              acq_ok  = (cand >= acq_thr) && sq2_pass;
  wire              window  = sym_strobe && (sym_cnt == SYM_LAST);
  wire              too_low = sample < trk_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      dwell_best <= '0;
      held       <= '0;
      last_meas  <= '0;
      sym_cnt    <= '0;
      lost       <= 1'b0;
    end else begin
      lost <= 1'b0;
      unique case (st)
        S_IDLE: if (arm) st <= S_ACQ;
        S_ACQ: begin
          if (dwell_end) begin
            held       <= cand;
            dwell_best <= '0;
            if (acq_ok) begin
              st        <= S_LOCK;
              sym_cnt   <= '0;
              last_meas <= cand;
            end
          end else begin
            dwell_best <= cand;
          end
        end
        S_LOCK: begin
          if (meas_valid) last_meas <= meas;
          if (sym_strobe) sym_cnt <= sym_cnt + 1'b1;
          if (window && too_low) begin
            st         <= S_ACQ;
            lost       <= 1'b1;
            dwell_best <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign state   = st;
  assign best_hi = held[MEAS_W-1:8];
  assign best_lo = held[7:0];

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_IDLE && st != S_IDLE) |-> (st == S_ACQ && $past(arm)));

  // R4
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOCK && $past(st) != S_LOCK) |-> ($past(st) == S_ACQ && $past(dwell_end) && $past(sq2_pass)));

  // R6
  drop_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_LOCK && st != S_LOCK) |-> ($past(sym_strobe) && $past(sym_cnt) == SYM_LAST && lost));

  // R6
  lost_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (st == S_ACQ && $past(st) == S_LOCK));

  // R8
  held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_LOCK) |-> $stable(held));

endmodule

// File: tb/tb_sq_lock_monitor.sv
module tb_sq_lock_monitor;
  logic clk = 0, rst_n = 0, arm = 0;
  logic [6:0] acq_thr_hi = 7'h12, trk_thr_hi = 7'h08;
  logic [7:0] acq_thr_lo = 8'h34, trk_thr_lo = 8'h00;
  logic meas_valid = 0, dwell_end = 0, sq2_pass = 0, sym_strobe = 0;
  logic [14:0] meas = 0;
  logic [1:0] state;
  logic [6:0] best_hi;
  logic [7:0] best_lo;
  logic lost;

  always #4 clk = ~clk;

  sq_lock_monitor dut (.clk, .rst_n, .arm, .acq_thr_hi, .acq_thr_lo, .trk_thr_hi, .trk_thr_lo,
    .meas_valid, .meas, .dwell_end, .sq2_pass, .sym_strobe, .state, .best_hi, .best_lo, .lost);

  typedef struct {int due; logic [1:0] st; logic [14:0] best; logic lost; string req;} exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state, from the requirements
  logic [1:0] m_st = 0;
  logic [14:0] m_dbest = 0, m_held = 0, m_last = 0;
  int m_cnt = 0;

  task automatic drive(input logic a, input logic mv, input logic [14:0] m,
                       input logic de, input logic sq, input logic ss, input string req);
    logic [14:0] c, s;
    logic ml;
    @(posedge clk); #1;
    arm = a; meas_valid = mv; meas = m; dwell_end = de; sq2_pass = sq; sym_strobe = ss;
    ml = 0;
    case (m_st)
      2'd0: if (a) m_st = 2'd1;
      2'd1: begin
        c = (mv && m > m_dbest) ? m : m_dbest;
        if (de) begin
          m_held = c; m_dbest = 0;
          if (c >= 15'h1234 && sq) begin m_st = 2'd2; m_cnt = 0; m_last = c; end
        end else m_dbest = c;
      end
      default: begin
        s = mv ? m : m_last;
        if (mv) m_last = m;
        if (ss) begin
          if (m_cnt == 127 && s < 15'h0800) begin m_st = 2'd1; ml = 1; m_dbest = 0; end
          m_cnt = (m_cnt + 1) % 128;
        end
      end
    endcase
    q.push_back('{cyc + 1, m_st, m_held, ml, req});
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic strobes(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0, 1, req);
      drive(0, 0, 0, 0, 0, 0, req);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (state !== e.st || {best_hi, best_lo} !== e.best || lost !== e.lost) begin
        fails++;
        $display("FAIL %s cyc %0d: state=%0d best=%h lost=%b expected state=%0d best=%h lost=%b",
                 e.req, cyc, state, {best_hi, best_lo}, lost, e.st, e.best, e.lost);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (state !== 2'd0 || {best_hi, best_lo} !== 15'h0 || lost !== 1'b0) begin
      fails++;
      $display("FAIL R1: state=%0d best=%h lost=%b expected 0 0000 0", state, {best_hi, best_lo}, lost);
    end
    @(posedge clk); #1 rst_n = 1;
    // R2: inputs ignored in idle, then arm
    drive(0, 1, 15'h7000, 1, 1, 1, "R2");
    drive(0, 0, 0, 1, 1, 0, "R2");
    drive(1, 0, 0, 0, 0, 0, "R2");
    idle(2, "R2");
    // R3/R5: weak dwell
    drive(0, 1, 15'h0100, 0, 0, 0, "R3");
    drive(0, 1, 15'h0500, 0, 0, 0, "R3");
    drive(0, 1, 15'h0300, 0, 0, 0, "R3");
    drive(0, 0, 0, 1, 1, 0, "R5");
    // R5: strong amplitude but second test fails
    drive(0, 1, 15'h2000, 0, 0, 0, "R5");
    drive(0, 0, 0, 1, 0, 0, "R5");
    // R3: next dwell weaker, restart from zero
    drive(0, 1, 15'h0042, 0, 0, 0, "R3");
    drive(0, 0, 0, 1, 0, 0, "R3");
    // R4/R9: peak equal to threshold in dwell-end cycle
    drive(0, 1, 15'h0200, 0, 0, 0, "R4");
    drive(0, 1, 15'h1234, 1, 1, 0, "R4");
    // R8: readback frozen while locked
    drive(0, 1, 15'h7FFF, 1, 1, 0, "R8");
    drive(0, 0, 0, 1, 0, 0, "R8");
    // R6: equal to tracking threshold holds at the 128th strobe
    drive(0, 1, 15'h0800, 0, 0, 0, "R6");
    strobes(127, "R6");
    strobes(1, "R6");
    // R6: one below threshold drops at the next 128th strobe
    drive(0, 1, 15'h07FF, 0, 0, 0, "R6");
    strobes(127, "R6");
    strobes(1, "R6");
    idle(2, "R6");
    // R7: relock, no fresh amplitude, acquiring value used
    drive(0, 1, 15'h7FFF, 1, 1, 0, "R7");
    strobes(128, "R7");
    // R7: same-cycle amplitude used in the testing cycle
    strobes(127, "R7");
    drive(0, 1, 15'h0010, 0, 0, 1, "R7");
    idle(3, "R7");
    // R2-R9 spot: second acquisition via a stronger later report
    drive(0, 1, 15'h1233, 0, 0, 0, "R4");
    drive(0, 0, 0, 1, 1, 0, "R4");
    drive(0, 1, 15'h1300, 0, 0, 0, "R4");
    drive(0, 1, 15'h1200, 1, 1, 0, "R4");
    idle(2, "R4");
    wait (q.size() == 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule